// File: doc/BRIEF.md
# Floating-Point and Vector Access Trap Decider

This block judges, for a single floating-point or vector instruction, whether the access is blocked by one of three enable layers and, if so, which privilege level receives the trap. Its inputs are the current privilege level, the control fields and trap bits of each layer, and a handful of routing and presence flags. A request strobe samples them. One clock later a registered verdict appears: a trap flag, the destination level, the exception class and a flag telling whether the 5-bit condition syndrome belongs in the report.

The three layers are fixed in priority. The kernel layer is checked first, then the hypervisor layer, then the monitor layer, and the first layer that blocks decides the outcome. A trap aimed at the kernel level can be diverted to the hypervisor level when guest routing is active. A diverted trap is reported as uncategorized and without a condition field. Taking the exception is left to the surrounding core.

Top module: `fpv_trap_gate`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `verdict_vld_o`, `trap_o` and `cond_incl_o` are 0 and `tgt_lvl_o` and `exc_cls_o` are 0.
- R2: A request sampled on clock edge N produces its verdict at the outputs after edge N, with `verdict_vld_o` high for exactly that one cycle. When no request is sampled, `verdict_vld_o` is 0 and all verdict outputs keep their previous values.
- R3: The kernel layer applies only at levels 0 and 1 while `in_host_i` is 0. Its mode field `krn_mode_i` works as follows: bit 0 clear blocks; `01` blocks only at level 0; `11` never blocks. A kernel-layer block targets level 1.
- R4: The hypervisor layer applies at levels 0, 1 and 2 while `hyp_on_i` is 1. With `host_ext_i` set, `hyp_mode_i` works as follows: bit 0 clear blocks unless the level is 1 with `guest_route_i` 1; `01` blocks only at level 0 with `guest_route_i` 1; `11` never blocks. A block targets level 2.
- R5: With `host_ext_i` clear, the hypervisor layer blocks when `hyp_block_i` is 1, targeting level 2.
- R6: When `mon_here_i` and `mon_block_i` are both 1, the monitor layer blocks at any level, targeting level 3.
- R7: When several layers block, the kernel layer wins over the hypervisor layer, and the hypervisor layer wins over the monitor layer.
- R8: A kernel-layer block with `hyp_on_i` and `guest_route_i` both 1 is reported with target level 2, class 0x00 and `cond_incl_o` 0.
- R9: Every trap that is not diverted is reported with class 0x07 and `cond_incl_o` 1.
- R10: When no layer blocks, `trap_o` is 0 and `tgt_lvl_o`, `exc_cls_o` and `cond_incl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe; samples all decision inputs |
| cur_lvl_i | input | 2 | Current privilege level, 0 to 3 |
| krn_mode_i | input | 2 | Kernel-layer enable mode |
| hyp_mode_i | input | 2 | Hypervisor-layer enable mode, used with host extension |
| hyp_block_i | input | 1 | Hypervisor-layer trap bit, used without host extension |
| mon_block_i | input | 1 | Monitor-layer trap bit |
| host_ext_i | input | 1 | Host extension active |
| guest_route_i | input | 1 | Guest routing to the hypervisor level active |
| hyp_on_i | input | 1 | Hypervisor level enabled |
| mon_here_i | input | 1 | Monitor level implemented |
| in_host_i | input | 1 | Execution is in host mode |
| verdict_vld_o | output | 1 | One-cycle pulse marking a fresh verdict |
| trap_o | output | 1 | Access is blocked |
| tgt_lvl_o | output | 2 | Level that receives the trap |
| exc_cls_o | output | 6 | Exception class: 0x07 or 0x00 |
| cond_incl_o | output | 1 | Condition syndrome belongs in the report |

## Verification
The kernel layer is tried with each mode value at levels 0, 1 and 2 and with host mode on. This separates the level-0-only mode from the always-blocking modes and shows the scope limit. The hypervisor layer is driven with and without the host extension, crossed with guest routing and the level, which exposes the exempt level-1 case and the level-0-only case. Overlapping blocks from two or three layers show the priority order. Kernel blocks with and without routing show the diversion to an uncategorized class. A final sweep over every input combination compares all outputs against a model built from the requirements.

// File: rtl/fpv_trap_pkg.sv
package fpv_trap_pkg;
  localparam int LVL_W = 2;
  localparam int CLS_W = 6;
  localparam int MODE_W = 2;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [CLS_W-1:0]  cls_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam lvl_t LVL_USR = 2'd0;
  localparam lvl_t LVL_KRN = 2'd1;
  localparam lvl_t LVL_HYP = 2'd2;
  localparam lvl_t LVL_MON = 2'd3;

  localparam cls_t CLS_UNCAT = 6'h00;
  localparam cls_t CLS_FPV   = 6'h07;

  typedef struct packed {
    logic trap;
    lvl_t tgt;
    cls_t cls;
    logic cond;
  } verdict_t;
endpackage

// File: rtl/fpv_rst_sync.sv
module fpv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = shift_q[STAGES-1];
endmodule

// File: rtl/fpv_gate_krn.sv
module fpv_gate_krn
  import fpv_trap_pkg::*;
(
  input  lvl_t  cur_lvl_i,
  input  mode_t mode_i,
  input  logic  in_host_i,
  output logic  block_o
);
  logic in_scope;

  assign in_scope = ((cur_lvl_i == LVL_USR) || (cur_lvl_i == LVL_KRN)) && !in_host_i;

  always_comb begin
    block_o = 1'b0;
    if (in_scope) begin
      case (mode_i)
        2'b01:   block_o = (cur_lvl_i == LVL_USR);
        2'b11:   block_o = 1'b0;
        default: block_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fpv_gate_hyp.sv
module fpv_gate_hyp
  import fpv_trap_pkg::*;
#(
  parameter bit HAS_HOST_EXT = 1'b1
) (
  input  lvl_t  cur_lvl_i,
  input  mode_t mode_i,
  input  logic  block_bit_i,
  input  logic  host_ext_i,
  input  logic  guest_route_i,
  input  logic  hyp_on_i,
  output logic  block_o
);
  logic in_scope;

  assign in_scope = hyp_on_i && (cur_lvl_i != LVL_MON);

  generate
    if (HAS_HOST_EXT) begin : g_ext
      logic mode_block;
      always_comb begin
        case (mode_i)
          2'b01:   mode_block = (cur_lvl_i == LVL_USR) && guest_route_i;
          2'b11:   mode_block = 1'b0;
          default: mode_block = !((cur_lvl_i == LVL_KRN) && guest_route_i);
        endcase
      end
      assign block_o = in_scope && (host_ext_i ? mode_block : block_bit_i);
    end else begin : g_plain
      assign block_o = in_scope && block_bit_i;
    end
  endgenerate
endmodule

// File: rtl/fpv_arbiter.sv
module fpv_arbiter
  import fpv_trap_pkg::*;
(
  input  logic     krn_block_i,
  input  logic     hyp_block_i,
  input  logic     mon_block_i,
  input  logic     hyp_on_i,
  input  logic     guest_route_i,
  output verdict_t verdict_o
);
  logic divert;

  assign divert = hyp_on_i && guest_route_i;

  always_comb begin
    verdict_o = '0;
    if (krn_block_i) begin
      if (divert) begin
        verdict_o.trap = 1'b1;
        verdict_o.tgt  = LVL_HYP;
        verdict_o.cls  = CLS_UNCAT;
        verdict_o.cond = 1'b0;
      end else begin
        verdict_o.trap = 1'b1;
        verdict_o.tgt  = LVL_KRN;
        verdict_o.cls  = CLS_FPV;
        verdict_o.cond = 1'b1;
      end
    end else if (hyp_block_i) begin
      verdict_o.trap = 1'b1;
      verdict_o.tgt  = LVL_HYP;
      verdict_o.cls  = CLS_FPV;
      verdict_o.cond = 1'b1;
    end else if (mon_block_i) begin
      verdict_o.trap = 1'b1;
      verdict_o.tgt  = LVL_MON;
      verdict_o.cls  = CLS_FPV;
      verdict_o.cond = 1'b1;
    end
  end
endmodule

// File: rtl/fpv_trap_gate.sv
module fpv_trap_gate
  import fpv_trap_pkg::*;
#(
  parameter bit HAS_HOST_EXT = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] cur_lvl_i,
  input  logic [1:0] krn_mode_i,
  input  logic [1:0] hyp_mode_i,
  input  logic       hyp_block_i,
  input  logic       mon_block_i,
  input  logic       host_ext_i,
  input  logic       guest_route_i,
  input  logic       hyp_on_i,
  input  logic       mon_here_i,
  input  logic       in_host_i,
  output logic       verdict_vld_o,
  output logic       trap_o,
  output logic [1:0] tgt_lvl_o,
  output logic [5:0] exc_cls_o,
  output logic       cond_incl_o
);
  logic     rst_sync_n;
  logic     krn_blk, hyp_blk, mon_blk;
  verdict_t verdict_w, verdict_d, verdict_q;
  logic     vld_d, vld_q;

  fpv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  fpv_gate_krn u_krn (
    .cur_lvl_i (cur_lvl_i),
    .mode_i    (krn_mode_i),
    .in_host_i (in_host_i),
    .block_o   (krn_blk)
  );

  fpv_gate_hyp #(.HAS_HOST_EXT(HAS_HOST_EXT)) u_hyp (
    .cur_lvl_i     (cur_lvl_i),
    .mode_i        (hyp_mode_i),
    .block_bit_i   (hyp_block_i),
    .host_ext_i    (host_ext_i),
    .guest_route_i (guest_route_i),
    .hyp_on_i      (hyp_on_i),
    .block_o       (hyp_blk)
  );

  assign mon_blk = mon_here_i && mon_block_i;

  fpv_arbiter u_arb (
    .krn_block_i   (krn_blk),
    .hyp_block_i   (hyp_blk),
    .mon_block_i   (mon_blk),
    .hyp_on_i      (hyp_on_i),
    .guest_route_i (guest_route_i),
    .verdict_o     (verdict_w)
  );

  // next state: capture on request, hold otherwise
  always_comb begin
    vld_d     = req_i;
    verdict_d = verdict_q;
    if (req_i) verdict_d = verdict_w;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q     <= 1'b0;
      verdict_q <= '0;
    end else begin
      vld_q     <= vld_d;
      verdict_q <= verdict_d;
    end
  end

  assign verdict_vld_o = vld_q;
  assign trap_o        = verdict_q.trap;
  assign tgt_lvl_o     = verdict_q.tgt;
  assign exc_cls_o     = verdict_q.cls;
  assign cond_incl_o   = verdict_q.cond;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    req_i |=> verdict_vld_o); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !req_i |=> (!verdict_vld_o && $stable(trap_o) && $stable(tgt_lvl_o)
                && $stable(exc_cls_o) && $stable(cond_incl_o))); // R2

  AST_QUIET_WHEN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !trap_o |-> (tgt_lvl_o == LVL_USR && exc_cls_o == CLS_UNCAT && !cond_incl_o)); // R10

  AST_UNCAT_IS_DIVERTED: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (trap_o && exc_cls_o == CLS_UNCAT) |-> (tgt_lvl_o == LVL_HYP && !cond_incl_o)); // R8

  AST_FPV_CARRIES_COND: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (trap_o && exc_cls_o == CLS_FPV) |-> cond_incl_o); // R9

  AST_MON_AT_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (req_i && cur_lvl_i == LVL_MON && mon_here_i && mon_block_i)
      |=> (trap_o && tgt_lvl_o == LVL_MON)); // R6

  AST_KRN_OUT_OF_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (req_i && cur_lvl_i == LVL_HYP && !hyp_on_i && !(mon_here_i && mon_block_i))
      |=> !trap_o); // R3

  AST_TRAP_NEVER_USR: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    trap_o |-> (tgt_lvl_o != LVL_USR)); // R7
endmodule

// File: tb/fpv_trap_gate_tb.sv
module fpv_trap_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [1:0] lvl, m1, m2;
  logic       b2, b3, he, rt, on, l3, ih;
  logic       vld, trap, cond;
  logic [1:0] tgt;
  logic [5:0] cls;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpv_trap_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cur_lvl_i(lvl),
    .krn_mode_i(m1), .hyp_mode_i(m2), .hyp_block_i(b2), .mon_block_i(b3),
    .host_ext_i(he), .guest_route_i(rt), .hyp_on_i(on), .mon_here_i(l3),
    .in_host_i(ih), .verdict_vld_o(vld), .trap_o(trap), .tgt_lvl_o(tgt),
    .exc_cls_o(cls), .cond_incl_o(cond)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected verdict {trap, tgt, cls, cond}, built from R3..R10
  function automatic logic [9:0] model(input logic [1:0] l, input logic [1:0] k,
      input logic [1:0] h, input logic hb, input logic mb, input logic e,
      input logic r, input logic o, input logic p, input logic hs);
    logic kb, yb, zb;
    kb = 1'b0; yb = 1'b0;
    if (l <= 2'd1 && !hs)
      kb = (k[0] == 1'b0) || (k == 2'b01 && l == 2'd0);
    if (o && l != 2'd3) begin
      if (e) yb = (h[0] == 1'b0) ? !(l == 2'd1 && r) : (h == 2'b01 && l == 2'd0 && r);
      else   yb = hb;
    end
    zb = p && mb;
    if (kb)      return (o && r) ? {1'b1, 2'd2, 6'h00, 1'b0} : {1'b1, 2'd1, 6'h07, 1'b1};
    else if (yb) return {1'b1, 2'd2, 6'h07, 1'b1};
    else if (zb) return {1'b1, 2'd3, 6'h07, 1'b1};
    return 10'd0;
  endfunction

  task automatic apply(input logic [1:0] l, input logic [1:0] k, input logic [1:0] h,
      input logic hb, input logic mb, input logic e, input logic r, input logic o,
      input logic p, input logic hs);
    @(negedge clk);
    lvl = l; m1 = k; m2 = h; b2 = hb; b3 = mb; he = e; rt = r; on = o; l3 = p; ih = hs;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_v(input string tag, input logic t, input logic [1:0] g,
      input logic [5:0] c, input logic d);
    chk({tag, " valid"}, vld, 1);
    chk({tag, " trap"}, trap, t);
    chk({tag, " target"}, tgt, g);
    chk({tag, " class"}, cls, c);
    chk({tag, " cond"}, cond, d);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", vld, 0);
    chk("R1 trap in reset", trap, 0);
    chk("R1 verdict in reset", {tgt, cls, cond}, 0);
  endtask

  task automatic t_krn_layer();
    apply(2'd1, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl1 mode00", 1, 2'd1, 6'h07, 1);
    apply(2'd1, 2'b10, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl1 mode10", 1, 2'd1, 6'h07, 1);
    apply(2'd1, 2'b01, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl1 mode01", 0, 2'd0, 6'h00, 0);
    apply(2'd0, 2'b01, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl0 mode01", 1, 2'd1, 6'h07, 1);
    apply(2'd0, 2'b11, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl0 mode11", 0, 2'd0, 6'h00, 0);
    apply(2'd0, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 1); expect_v("R3 host mode", 0, 2'd0, 6'h00, 0);
    apply(2'd2, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R3 lvl2 scope", 0, 2'd0, 6'h00, 0);
  endtask

  task automatic t_hyp_ext();
    apply(2'd0, 2'b11, 2'b00, 0, 0, 1, 0, 1, 0, 0); expect_v("R4 lvl0 mode00", 1, 2'd2, 6'h07, 1);
    apply(2'd1, 2'b11, 2'b00, 0, 0, 1, 1, 1, 0, 0); expect_v("R4 lvl1 route exempt", 0, 2'd0, 6'h00, 0);
    apply(2'd1, 2'b11, 2'b10, 0, 0, 1, 0, 1, 0, 0); expect_v("R4 lvl1 mode10", 1, 2'd2, 6'h07, 1);
    apply(2'd0, 2'b11, 2'b01, 0, 0, 1, 1, 1, 0, 0); expect_v("R4 lvl0 mode01 route", 1, 2'd2, 6'h07, 1);
    apply(2'd0, 2'b11, 2'b01, 0, 0, 1, 0, 1, 0, 0); expect_v("R4 lvl0 mode01 noroute", 0, 2'd0, 6'h00, 0);
    apply(2'd1, 2'b11, 2'b01, 0, 0, 1, 1, 1, 0, 1); expect_v("R4 lvl1 mode01", 0, 2'd0, 6'h00, 0);
    apply(2'd2, 2'b11, 2'b11, 1, 0, 1, 0, 1, 0, 0); expect_v("R4 mode11 ignores bit", 0, 2'd0, 6'h00, 0);
    apply(2'd2, 2'b11, 2'b00, 0, 0, 1, 0, 1, 0, 0); expect_v("R4 lvl2 mode00", 1, 2'd2, 6'h07, 1);
    apply(2'd3, 2'b11, 2'b00, 0, 0, 1, 0, 1, 0, 0); expect_v("R4 lvl3 scope", 0, 2'd0, 6'h00, 0);
  endtask

  task automatic t_hyp_plain();
    apply(2'd2, 2'b00, 2'b00, 1, 0, 0, 0, 1, 0, 0); expect_v("R5 bit set", 1, 2'd2, 6'h07, 1);
    apply(2'd2, 2'b00, 2'b00, 0, 0, 0, 0, 1, 0, 0); expect_v("R5 bit clear", 0, 2'd0, 6'h00, 0);
    apply(2'd2, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, 0); expect_v("R5 hyp off", 0, 2'd0, 6'h00, 0);
  endtask

  task automatic t_mon();
    apply(2'd3, 2'b00, 2'b00, 1, 1, 0, 0, 1, 1, 0); expect_v("R6 lvl3", 1, 2'd3, 6'h07, 1);
    apply(2'd0, 2'b11, 2'b11, 0, 1, 0, 0, 0, 1, 0); expect_v("R6 lvl0", 1, 2'd3, 6'h07, 1);
    apply(2'd3, 2'b00, 2'b00, 0, 1, 0, 0, 0, 0, 0); expect_v("R6 absent", 0, 2'd0, 6'h00, 0);
  endtask

  task automatic t_priority();
    apply(2'd0, 2'b00, 2'b00, 1, 1, 0, 0, 1, 1, 0); expect_v("R7 krn wins", 1, 2'd1, 6'h07, 1);
    apply(2'd0, 2'b11, 2'b00, 1, 1, 0, 0, 1, 1, 0); expect_v("R7 hyp wins", 1, 2'd2, 6'h07, 1);
  endtask

  task automatic t_divert();
    apply(2'd0, 2'b00, 2'b00, 0, 1, 0, 1, 1, 1, 0); expect_v("R8 diverted", 1, 2'd2, 6'h00, 0);
    apply(2'd1, 2'b00, 2'b00, 0, 0, 0, 1, 0, 0, 0); expect_v("R9 route w/o hyp", 1, 2'd1, 6'h07, 1);
  endtask

  task automatic t_hold();
    apply(2'd1, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    lvl = 2'd0; m1 = 2'b11; l3 = 1'b1; b3 = 1'b1;
    @(negedge clk);
    chk("R2 valid drops", vld, 0);
    chk("R2 verdict held", {trap, tgt, cls, cond}, {1'b1, 2'd1, 6'h07, 1'b1});
    apply(2'd0, 2'b11, 2'b11, 0, 0, 0, 0, 0, 0, 0); expect_v("R10 open", 0, 2'd0, 6'h00, 0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      logic [9:0]  e;
      v = 13'(i);
      apply(v[1:0], v[3:2], v[5:4], v[6], v[7], v[8], v[9], v[10], v[11], v[12]);
      e = model(v[1:0], v[3:2], v[5:4], v[6], v[7], v[8], v[9], v[10], v[11], v[12]);
      chk($sformatf("R7 R9 R10 sweep %0d", i), {trap, tgt, cls, cond}, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; lvl = '0; m1 = '0; m2 = '0;
    b2 = 0; b3 = 0; he = 0; rt = 0; on = 0; l3 = 0; ih = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_krn_layer();
    t_hyp_ext();
    t_hyp_plain();
    t_mon();
    t_priority();
    t_divert();
    t_hold();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule